// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode controller of a small microcontroller-style system. After reset it sits in Run. A software request moves it into one of three low-power modes. Sleep gates only the processor clock. Stop gates every core-domain clock, shuts the PLL and both main oscillators, and can drop the regulator to low-power mode. Standby switches the regulator off and the core domain loses power. Each mode has its own set of wake sources. Sleep and Stop resume into Run. Leaving Standby is handled as a reset: the block pulses a core reset for one cycle and then starts Run on the main regulator.

The block also gates a software-enabled supply-monitor comparator into an interrupt. That interrupt doubles as a wake source for Stop. A backup-domain retention flag is raised when Standby is entered and stays set. Analog regulation, the oscillators and the real threshold comparison are modelled as plain digital signals.

Top module: `lpm_sequencer`

## Requirements
- R1: After `rstN` is released the block is in Run. In that state `modeOut`=0, all five clock and oscillator enables are 1, `regMode`=0 (main), and `backupRetain`, `coreRstOut`, `pvdIrq` and `wakeSrc` are 0. In every Run cycle the regulator is in main mode and both clocks are enabled.
- R2: In Run, `swEnterReq` takes effect at the next clock edge. `swModeSel` 0 selects Sleep, 1 selects Stop and 2 selects Standby. The value 3 is ignored and the block stays in Run. `modeOut` reports 0 Run, 1 Sleep, 2 Stop and its wake-up wait, and 3 Standby and its reset pulse.
- R3: In Sleep, `cpuClkEn`=0 and `coreClkEn`, `pllEn`, `hsiEn`, `hseEn` are 1, with `regMode`=0. A high `irqPending` returns the block to Run at the next edge.
- R4: In Stop, all five enables are 0. `regMode` is 1 (low-power) if `swStopLowPwr` was 1 when Stop was entered, and 0 (main) otherwise.
- R5: In Stop, any set `wakeEvt` bit or a high `pvdIrq` starts the wake-up wait. During the wait the oscillators and PLL are on, both clocks are gated and `regMode`=0. Run follows `WAIT_CYCLES` (default 4) edges after the wait begins. `wakeSrc` records the lowest set event index, or 18 when only the supply monitor caused the wake.
- R6: In Standby, all five enables are 0 and `regMode`=2 (off).
- R7: Standby is left only on `extResetReq`, `wdtResetReq`, a rising edge of `wakePin` (after a two-flop synchronizer), or `wakeEvt[16]` (the real-time-clock alarm line). Other event lines and `irqPending` have no effect there.
- R8: Leaving Standby, or a reset request in any mode, gives exactly one cycle with `coreRstOut`=1, `modeOut`=3, the oscillators on and the clocks gated. The next cycle is Run with the main regulator.
- R9: `backupRetain` goes to 1 when Standby is entered and stays 1 until `rstN`.
- R10: `pvdIrq` is the registered AND of `pvdEnable` and `pvdBelow`. It is 0 whenever the monitor is disabled.
- R11: An entry request is refused, and the block stays in Run, if a wake condition for the requested mode is already present: `irqPending` for Sleep, any event line or `pvdIrq` for Stop, a high synchronized `wakePin` or the alarm line for Standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| swEnterReq | input | 1 | Software low-power entry request |
| swModeSel | input | 2 | Requested mode: 0 Sleep, 1 Stop, 2 Standby |
| swStopLowPwr | input | 1 | Use the low-power regulator in Stop |
| irqPending | input | 1 | Any pending interrupt or event (Sleep wake) |
| wakeEvt | input | 18 | Event lines: 0-15 external, 16 RTC alarm, 17 USB wake |
| wakePin | input | 1 | Asynchronous wake pin |
| extResetReq | input | 1 | External reset request |
| wdtResetReq | input | 1 | Independent watchdog reset request |
| pvdEnable | input | 1 | Software enable of the supply monitor |
| pvdBelow | input | 1 | Comparator: supply below threshold |
| cpuClkEn | output | 1 | Processor clock enable |
| coreClkEn | output | 1 | Core-domain peripheral clock enable |
| pllEn | output | 1 | PLL enable |
| hsiEn | output | 1 | Internal RC oscillator enable |
| hseEn | output | 1 | Crystal oscillator enable |
| regMode | output | 2 | Regulator: 0 main, 1 low-power, 2 off |
| backupRetain | output | 1 | Backup-domain retention flag |
| coreRstOut | output | 1 | One-shot core reset |
| pvdIrq | output | 1 | Supply-monitor interrupt |
| wakeSrc | output | 5 | Index of the event that last ended Stop |
| modeOut | output | 2 | Current mode code |

## Verification
The collision of interest is an entry request that arrives in the same cycle as a wake condition for the mode it asks for. The bench provokes it three ways: `irqPending` together with a Sleep request, an event line together with a Stop request, and a `wakePin` that is already high and synchronized together with a Standby request. It judges each case by checking that the block is still in Run one edge later. A second overlap is the supply-monitor interrupt rising while the block is in Stop. That one edge must both raise `pvdIrq` and, one edge later, start the wake-up wait with source 18.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STOP    = 3'd2,
    ST_WAKEUP  = 3'd3,
    ST_STANDBY = 3'd4,
    ST_CORERST = 3'd5
  } lpmState_t;

  localparam logic [1:0] REG_MAIN   = 2'd0;
  localparam logic [1:0] REG_LOWPWR = 2'd1;
  localparam logic [1:0] REG_OFF    = 2'd2;

  localparam logic [1:0] SEL_SLEEP   = 2'd0;
  localparam logic [1:0] SEL_STOP    = 2'd1;
  localparam logic [1:0] SEL_STANDBY = 2'd2;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_STOP  = 2'd2;
  localparam logic [1:0] MODE_STBY  = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic latchSrc;
  } ctrlStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic stopWake;
    logic stbyWake;
    logic stbyBlock;
    logic cntDone;
  } dpStatus_t;

endpackage

// File: rtl/lpm_dpath.sv
module lpm_dpath
  import lpm_pkg::*;
#(
  parameter int NUM_EVT     = 18,
  parameter int RTC_LINE    = 16,
  parameter int WAIT_CYCLES = 4,
  parameter int SRC_W       = 5,
  parameter int CNT_W       = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] wakeEvt,
  input  logic               wakePin,
  input  logic               extResetReq,
  input  logic               wdtResetReq,
  input  logic               pvdEnable,
  input  logic               pvdBelow,
  input  ctrlStrobe_t        strobe,
  output dpStatus_t          status,
  output logic               pvdIrq,
  output logic [SRC_W-1:0]   wakeSrc
);

  localparam logic [SRC_W-1:0] PVD_SRC  = SRC_W'(NUM_EVT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  logic             pinMeta, pinSync, pinLast;
  logic             pinRise;
  logic [CNT_W-1:0] waitCnt;
  logic [SRC_W-1:0] nextSrc;

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= 1'b0;
      pinSync <= 1'b0;
      pinLast <= 1'b0;
    end else begin
      pinMeta <= wakePin;
      pinSync <= pinMeta;
      pinLast <= pinSync;
    end
  end

  assign pinRise = pinSync & ~pinLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pvdIrq <= 1'b0;
    else       pvdIrq <= pvdEnable & pvdBelow;
  end

  // oscillator settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitCnt <= '0;
    else if (strobe.cntClr)     waitCnt <= '0;
    else if (waitCnt != CNT_LAST) waitCnt <= waitCnt + CNT_W'(1);
  end

  // lowest set line wins; monitor only when no line is set
  always_comb begin
    nextSrc = PVD_SRC;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (wakeEvt[i]) nextSrc = SRC_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wakeSrc <= '0;
    else if (strobe.latchSrc) wakeSrc <= nextSrc;
  end

  assign status.stopWake  = (|wakeEvt) | pvdIrq;
  assign status.stbyWake  = extResetReq | wdtResetReq | pinRise | wakeEvt[RTC_LINE];
  assign status.stbyBlock = extResetReq | wdtResetReq | pinSync | wakeEvt[RTC_LINE];
  assign status.cntDone   = (waitCnt == CNT_LAST);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swEnterReq,
  input  logic [1:0]  swModeSel,
  input  logic        swStopLowPwr,
  input  logic        irqPending,
  input  logic        extResetReq,
  input  logic        wdtResetReq,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        cpuClkEn,
  output logic        coreClkEn,
  output logic        pllEn,
  output logic        hsiEn,
  output logic        hseEn,
  output logic [1:0]  regMode,
  output logic        backupRetain,
  output logic        coreRstOut,
  output logic [1:0]  modeOut
);

  lpmState_t state, nextState;
  logic      stopLp;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (extResetReq || wdtResetReq) begin
      nextState = ST_CORERST;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (swEnterReq) begin
            case (swModeSel)
              SEL_SLEEP:   if (!irqPending)       nextState = ST_SLEEP;
              SEL_STOP:    if (!status.stopWake)  nextState = ST_STOP;
              SEL_STANDBY: if (!status.stbyBlock) nextState = ST_STANDBY;
              default:     nextState = ST_RUN;
            endcase
          end
        end
        ST_SLEEP:   if (irqPending) nextState = ST_RUN;
        ST_STOP: begin
          if (status.stopWake) begin
            nextState       = ST_WAKEUP;
            strobe.cntClr   = 1'b1;
            strobe.latchSrc = 1'b1;
          end
        end
        ST_WAKEUP:  if (status.cntDone)  nextState = ST_RUN;
        ST_STANDBY: if (status.stbyWake) nextState = ST_CORERST;
        ST_CORERST: nextState = ST_RUN;
        default:    nextState = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_RUN;
      stopLp       <= 1'b0;
      backupRetain <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_RUN && nextState == ST_STOP) stopLp <= swStopLowPwr;
      if (nextState == ST_STANDBY) backupRetain <= 1'b1;
    end
  end

  // output decode per state
  always_comb begin
    cpuClkEn   = 1'b1;
    coreClkEn  = 1'b1;
    pllEn      = 1'b1;
    hsiEn      = 1'b1;
    hseEn      = 1'b1;
    regMode    = REG_MAIN;
    coreRstOut = 1'b0;
    modeOut    = MODE_RUN;
    unique case (state)
      ST_SLEEP: begin
        cpuClkEn = 1'b0;
        modeOut  = MODE_SLEEP;
      end
      ST_STOP: begin
        cpuClkEn  = 1'b0;
        coreClkEn = 1'b0;
        pllEn     = 1'b0;
        hsiEn     = 1'b0;
        hseEn     = 1'b0;
        regMode   = stopLp ? REG_LOWPWR : REG_MAIN;
        modeOut   = MODE_STOP;
      end
      ST_WAKEUP: begin
        cpuClkEn  = 1'b0;
        coreClkEn = 1'b0;
        modeOut   = MODE_STOP;
      end
      ST_STANDBY: begin
        cpuClkEn  = 1'b0;
        coreClkEn = 1'b0;
        pllEn     = 1'b0;
        hsiEn     = 1'b0;
        hseEn     = 1'b0;
        regMode   = REG_OFF;
        modeOut   = MODE_STBY;
      end
      ST_CORERST: begin
        cpuClkEn   = 1'b0;
        coreClkEn  = 1'b0;
        coreRstOut = 1'b1;
        modeOut    = MODE_STBY;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_EVT     = 18,
  parameter int RTC_LINE    = 16,
  parameter int WAIT_CYCLES = 4,
  localparam int SRC_W      = $clog2(NUM_EVT + 1),
  localparam int CNT_W      = $clog2(WAIT_CYCLES) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swEnterReq,
  input  logic [1:0]         swModeSel,
  input  logic               swStopLowPwr,
  input  logic               irqPending,
  input  logic [NUM_EVT-1:0] wakeEvt,
  input  logic               wakePin,
  input  logic               extResetReq,
  input  logic               wdtResetReq,
  input  logic               pvdEnable,
  input  logic               pvdBelow,
  output logic               cpuClkEn,
  output logic               coreClkEn,
  output logic               pllEn,
  output logic               hsiEn,
  output logic               hseEn,
  output logic [1:0]         regMode,
  output logic               backupRetain,
  output logic               coreRstOut,
  output logic               pvdIrq,
  output logic [SRC_W-1:0]   wakeSrc,
  output logic [1:0]         modeOut
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  lpm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .swEnterReq   (swEnterReq),
    .swModeSel    (swModeSel),
    .swStopLowPwr (swStopLowPwr),
    .irqPending   (irqPending),
    .extResetReq  (extResetReq),
    .wdtResetReq  (wdtResetReq),
    .status       (status),
    .strobe       (strobe),
    .cpuClkEn     (cpuClkEn),
    .coreClkEn    (coreClkEn),
    .pllEn        (pllEn),
    .hsiEn        (hsiEn),
    .hseEn        (hseEn),
    .regMode      (regMode),
    .backupRetain (backupRetain),
    .coreRstOut   (coreRstOut),
    .modeOut      (modeOut)
  );

  lpm_dpath #(
    .NUM_EVT     (NUM_EVT),
    .RTC_LINE    (RTC_LINE),
    .WAIT_CYCLES (WAIT_CYCLES),
    .SRC_W       (SRC_W),
    .CNT_W       (CNT_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .wakeEvt     (wakeEvt),
    .wakePin     (wakePin),
    .extResetReq (extResetReq),
    .wdtResetReq (wdtResetReq),
    .pvdEnable   (pvdEnable),
    .pvdBelow    (pvdBelow),
    .strobe      (strobe),
    .status      (status),
    .pvdIrq      (pvdIrq),
    .wakeSrc     (wakeSrc)
  );

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       swEnterReq,
  input logic [1:0] swModeSel,
  input logic       irqPending,
  input logic       extResetReq,
  input logic       wdtResetReq,
  input logic       pvdEnable,
  input logic       pvdBelow,
  input logic       cpuClkEn,
  input logic       coreClkEn,
  input logic       pllEn,
  input logic       hsiEn,
  input logic       hseEn,
  input logic [1:0] regMode,
  input logic       backupRetain,
  input logic       coreRstOut,
  input logic       pvdIrq,
  input logic [1:0] modeOut
);

  logic noRst;
  assign noRst = !extResetReq && !wdtResetReq;

  p_run_main_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0) |-> (regMode == 2'd0 && cpuClkEn && coreClkEn));

  p_sleep_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd1 && irqPending && noRst) |=> (modeOut == 2'd0));

  p_stop_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd2 && !pllEn) |-> (!cpuClkEn && !coreClkEn && !hsiEn && !hseEn));

  p_standby_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd3 && !coreRstOut) |-> (regMode == 2'd2 && !pllEn && !hseEn));

  p_rst_oneshot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (coreRstOut && noRst) |=> (!coreRstOut && modeOut == 2'd0));

  p_retain_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    backupRetain |=> backupRetain);

  p_pvd_raise_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pvdEnable && pvdBelow) |=> pvdIrq);

  p_pvd_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pvdEnable |=> !pvdIrq);

  p_sleep_block_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0 && !coreRstOut && swEnterReq && swModeSel == 2'd0 && irqPending && noRst)
      |=> (modeOut == 2'd0));

endmodule

bind lpm_sequencer lpm_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .swEnterReq   (swEnterReq),
  .swModeSel    (swModeSel),
  .irqPending   (irqPending),
  .extResetReq  (extResetReq),
  .wdtResetReq  (wdtResetReq),
  .pvdEnable    (pvdEnable),
  .pvdBelow     (pvdBelow),
  .cpuClkEn     (cpuClkEn),
  .coreClkEn    (coreClkEn),
  .pllEn        (pllEn),
  .hsiEn        (hsiEn),
  .hseEn        (hseEn),
  .regMode      (regMode),
  .backupRetain (backupRetain),
  .coreRstOut   (coreRstOut),
  .pvdIrq       (pvdIrq),
  .modeOut      (modeOut)
);

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb;

  localparam int K_RUN = 0, K_SLEEP = 1, K_STOP = 2, K_STOPLP = 3,
                 K_WAKE = 4, K_STBY = 5, K_CRST = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swEnterReq = 1'b0;
  logic [1:0]  swModeSel = 2'd0;
  logic        swStopLowPwr = 1'b0;
  logic        irqPending = 1'b0;
  logic [17:0] wakeEvt = '0;
  logic        wakePin = 1'b0;
  logic        extResetReq = 1'b0;
  logic        wdtResetReq = 1'b0;
  logic        pvdEnable = 1'b0;
  logic        pvdBelow = 1'b0;
  logic        cpuClkEn, coreClkEn, pllEn, hsiEn, hseEn;
  logic [1:0]  regMode;
  logic        backupRetain, coreRstOut, pvdIrq;
  logic [4:0]  wakeSrc;
  logic [1:0]  modeOut;

  always #5 clk = ~clk;

  lpm_sequencer u_dut (
    .clk(clk), .rstN(rstN), .swEnterReq(swEnterReq), .swModeSel(swModeSel),
    .swStopLowPwr(swStopLowPwr), .irqPending(irqPending), .wakeEvt(wakeEvt),
    .wakePin(wakePin), .extResetReq(extResetReq), .wdtResetReq(wdtResetReq),
    .pvdEnable(pvdEnable), .pvdBelow(pvdBelow), .cpuClkEn(cpuClkEn),
    .coreClkEn(coreClkEn), .pllEn(pllEn), .hsiEn(hsiEn), .hseEn(hseEn),
    .regMode(regMode), .backupRetain(backupRetain), .coreRstOut(coreRstOut),
    .pvdIrq(pvdIrq), .wakeSrc(wakeSrc), .modeOut(modeOut)
  );

  typedef struct {
    string       tag;
    logic [16:0] val;
  } expItem_t;

  expItem_t   expQ[$];
  int         checks = 0;
  int         errors = 0;
  bit         retE = 1'b0;
  bit         irqE = 1'b0;
  logic [4:0] srcE = '0;

  logic [16:0] obsNow;
  assign obsNow = {modeOut, cpuClkEn, coreClkEn, pllEn, hsiEn, hseEn,
                   regMode, backupRetain, coreRstOut, pvdIrq, wakeSrc};

  function automatic logic [16:0] ex(int kind);
    logic [1:0] m; logic [4:0] en; logic [1:0] rg; logic rs;
    rs = 1'b0; rg = 2'd0;
    case (kind)
      K_RUN:    begin m = 2'd0; en = 5'b11111; end
      K_SLEEP:  begin m = 2'd1; en = 5'b01111; end
      K_STOP:   begin m = 2'd2; en = 5'b00000; end
      K_STOPLP: begin m = 2'd2; en = 5'b00000; rg = 2'd1; end
      K_WAKE:   begin m = 2'd2; en = 5'b00111; end
      K_STBY:   begin m = 2'd3; en = 5'b00000; rg = 2'd2; end
      default:  begin m = 2'd3; en = 5'b00111; rs = 1'b1; end
    endcase
    return {m, en, rg, retE, rs, irqE, srcE};
  endfunction

  // driver side: queue an expectation for the coming sample point
  task automatic expect_now(string tag, int kind);
    expItem_t it;
    it.tag = tag;
    it.val = ex(kind);
    expQ.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (obsNow !== it.val) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, obsNow, it.val);
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    expect_now("R1 reset state", K_RUN);
    step();

    // R3 Sleep entry and exit
    swEnterReq = 1'b1; swModeSel = 2'd0;
    step(); swEnterReq = 1'b0;
    expect_now("R3 sleep gating", K_SLEEP);
    step();
    expect_now("R3 sleep holds", K_SLEEP);
    irqPending = 1'b1;
    step(); irqPending = 1'b0;
    expect_now("R3 sleep exit on irq", K_RUN);

    // R11 sleep blocked by pending interrupt
    irqPending = 1'b1; swEnterReq = 1'b1; swModeSel = 2'd0;
    step(); irqPending = 1'b0; swEnterReq = 1'b0;
    expect_now("R11 sleep entry refused", K_RUN);

    // R2 selector value 3 ignored
    swEnterReq = 1'b1; swModeSel = 2'd3;
    step(); swEnterReq = 1'b0;
    expect_now("R2 reserved select ignored", K_RUN);

    // R4 Stop with low-power regulator, R5 wake on lines 5 and 9
    swStopLowPwr = 1'b1; swEnterReq = 1'b1; swModeSel = 2'd1;
    step(); swEnterReq = 1'b0; swStopLowPwr = 1'b0;
    expect_now("R4 stop low-power regulator", K_STOPLP);
    wakeEvt[5] = 1'b1; wakeEvt[9] = 1'b1;
    step(); wakeEvt = '0;
    srcE = 5'd5;
    expect_now("R5 wake wait begins, lowest line", K_WAKE);
    for (int i = 0; i < 3; i++) begin
      step();
      expect_now("R5 wake wait holds", K_WAKE);
    end
    step();
    expect_now("R5 run after wait", K_RUN);

    // R4 Stop with main regulator, R5/R10 wake by supply monitor
    swEnterReq = 1'b1; swModeSel = 2'd1;
    step(); swEnterReq = 1'b0;
    expect_now("R4 stop main regulator", K_STOP);
    pvdEnable = 1'b1; pvdBelow = 1'b1;
    step();
    irqE = 1'b1;
    expect_now("R10 monitor irq raised in stop", K_STOP);
    step();
    srcE = 5'd18;
    expect_now("R5 monitor wake source 18", K_WAKE);
    pvdBelow = 1'b0;
    step();
    irqE = 1'b0;
    expect_now("R10 monitor irq falls", K_WAKE);
    for (int i = 0; i < 2; i++) begin
      step();
      expect_now("R5 wake wait holds", K_WAKE);
    end
    step();
    expect_now("R5 run after monitor wake", K_RUN);

    // R10 disabled monitor gives no interrupt
    pvdEnable = 1'b0; pvdBelow = 1'b1;
    step();
    expect_now("R10 disabled monitor silent", K_RUN);
    step();
    expect_now("R10 disabled monitor silent", K_RUN);
    pvdBelow = 1'b0;

    // R11 stop blocked by event line
    wakeEvt[0] = 1'b1; swEnterReq = 1'b1; swModeSel = 2'd1;
    step(); wakeEvt = '0; swEnterReq = 1'b0;
    expect_now("R11 stop entry refused", K_RUN);

    // R6/R9 Standby entry, R7 ignore non-wake sources, pin edge exit
    swEnterReq = 1'b1; swModeSel = 2'd2;
    step(); swEnterReq = 1'b0;
    retE = 1'b1;
    expect_now("R6 standby all off", K_STBY);
    wakeEvt[3] = 1'b1; irqPending = 1'b1;
    step(); wakeEvt = '0; irqPending = 1'b0;
    expect_now("R7 line 3 and irq ignored", K_STBY);
    wakePin = 1'b1;
    step();
    expect_now("R7 pin in synchronizer", K_STBY);
    step();
    expect_now("R7 pin edge seen", K_STBY);
    step();
    expect_now("R8 core reset pulse", K_CRST);
    step();
    expect_now("R8 run after reset, R9 retain", K_RUN);

    // R11 standby blocked by high synchronized pin
    swEnterReq = 1'b1; swModeSel = 2'd2;
    step(); swEnterReq = 1'b0;
    expect_now("R11 standby entry refused", K_RUN);
    wakePin = 1'b0;
    repeat (3) step();

    // R7 alarm line exit
    swEnterReq = 1'b1; swModeSel = 2'd2;
    step(); swEnterReq = 1'b0;
    expect_now("R6 standby again", K_STBY);
    wakeEvt[16] = 1'b1;
    step(); wakeEvt = '0;
    expect_now("R7 alarm exit reset", K_CRST);
    step();
    expect_now("R8 run after alarm", K_RUN);

    // R8 watchdog reset from Sleep
    swEnterReq = 1'b1; swModeSel = 2'd0;
    step(); swEnterReq = 1'b0;
    expect_now("R3 sleep again", K_SLEEP);
    wdtResetReq = 1'b1;
    step(); wdtResetReq = 1'b0;
    expect_now("R8 watchdog reset pulse", K_CRST);
    step();
    expect_now("R8 run after watchdog", K_RUN);

    // R7 external reset leaves Standby
    swEnterReq = 1'b1; swModeSel = 2'd2;
    step(); swEnterReq = 1'b0;
    expect_now("R6 standby third", K_STBY);
    extResetReq = 1'b1;
    step(); extResetReq = 1'b0;
    expect_now("R7 external reset exit", K_CRST);
    step();
    expect_now("R9 retain kept after exit", K_RUN);

    step();
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule